// File: doc/BRIEF.md
# Doorbell Signal Interrupt Controller

This block lets processors ring numbered doorbells at one another. A doorbell is named by a 32-bit identifier word: the upper half holds a client number and the lower half a signal number. A write of such a word to the send command register, or a strobe on the remote send port that stands for another processor, marks that doorbell pending. Each doorbell also has an enable bit. A doorbell that is both pending and enabled drives a level-high summary interrupt.

Software services the interrupt by reading the receive register. The read returns one pending, enabled identifier at a time. The lowest client wins first, and within a client the lowest signal wins. Software then writes that identifier to the clear command register, and repeats until the all-ones sentinel comes back. Enable, disable and clear are also commands that take a packed identifier word, so no per-bit mask register exists.

Top module: `dbl_irq_ctrl`

## Requirements
- R1: An identifier word carries the client number in bits 31:16 and the signal number in bits 15:0. Writing it to offset 0x0C, or presenting it on the remote send port with its valid strobe high, makes that doorbell pending one clock later.
- R2: A read of offset 0x10 returns the identifier of a pending, enabled doorbell. When none exists it returns 0xFFFFFFFF.
- R3: Writing an identifier to offset 0x14 enables that doorbell. Writing it to offset 0x18 disables it, which hides it from the receive register and from the interrupt.
- R4: Writing an identifier to offset 0x1C clears that doorbell's pending state, and the receive register moves on to another doorbell.
- R5: The interrupt output is high exactly while at least one enabled doorbell is pending.
- R6: A doorbell raised while disabled stays pending. Enabling it later makes it visible and raises the interrupt.
- R7: Among several pending, enabled doorbells, the receive register reports the lowest client number first. A tie on client is broken by the lowest signal number.
- R8: Send, enable, disable and clear commands that name a client at or beyond NUM_CLIENTS, or a signal at or beyond NUM_SIGNALS, change no state.
- R9: Reads of any offset other than 0x10 return zero.
- R10: If a clear and a send of the same doorbell land in the same cycle, the doorbell remains pending.
- R11: A synchronous active-high reset clears all pending and enable state.
- R12: Repeatedly reading the receive register and clearing each returned identifier visits every pending, enabled doorbell once, in priority order, and then yields the sentinel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data (identifier word) |
| bus_rdata | output | 32 | Read data, combinational from address |
| rmt_send_vld | input | 1 | Remote processor send strobe |
| rmt_send_id | input | 32 | Identifier word raised by the remote sender |
| irq_out | output | 1 | Level-high summary interrupt |

## Verification
The bench uses the default build of 4 clients and 8 signals, which gives 32 doorbells. With this size the bench can reach client index 4 and signal index 8, one step past each limit, to test rejection. It can also put four doorbells from three different clients in flight at once, so ties on client number are resolved by signal number. The separate remote send port lets the bench put a send and a bus clear of the same doorbell into one cycle.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
  localparam int ID_W   = 32;
  localparam int HALF_W = 16;
  localparam logic [ID_W-1:0] NONE_ID = 32'hFFFF_FFFF;

  localparam logic [7:0] OFF_SEND = 8'h0C;
  localparam logic [7:0] OFF_RECV = 8'h10;
  localparam logic [7:0] OFF_EN   = 8'h14;
  localparam logic [7:0] OFF_DIS  = 8'h18;
  localparam logic [7:0] OFF_CLR  = 8'h1C;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_SEND, CMD_EN, CMD_DIS, CMD_CLR
  } cmd_e;

  // Decoder slots
  localparam int SLOT_BSEND = 0;
  localparam int SLOT_RSEND = 1;
  localparam int SLOT_EN    = 2;
  localparam int SLOT_DIS   = 3;
  localparam int SLOT_CLR   = 4;
  localparam int N_SLOTS    = 5;

  function automatic logic [ID_W-1:0] pack_id(logic [HALF_W-1:0] c, logic [HALF_W-1:0] s);
    return {c, s};
  endfunction

  function automatic logic [HALF_W-1:0] id_client(logic [ID_W-1:0] w);
    return w[ID_W-1:HALF_W];
  endfunction

  function automatic logic [HALF_W-1:0] id_signal(logic [ID_W-1:0] w);
    return w[HALF_W-1:0];
  endfunction
endpackage

// File: rtl/dbl_id_decode.sv
module dbl_id_decode
  import dbl_pkg::*;
#(
  parameter int NC = 4,
  parameter int NS = 8,
  localparam int NT = NC * NS
) (
  input  logic            act,
  input  logic [ID_W-1:0] id,
  output logic            in_range,
  output logic [NT-1:0]   hot
);
  int unsigned flat;

  always_comb begin
    in_range = (int'(id_client(id)) < NC) && (int'(id_signal(id)) < NS);
    flat     = int'(id_client(id)) * NS + int'(id_signal(id));
    hot      = '0;
    if (act && in_range) hot = {{(NT-1){1'b0}}, 1'b1} << flat;
  end
endmodule

// File: rtl/dbl_signal_bank.sv
module dbl_signal_bank #(
  parameter int NT = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NT-1:0] set_vec,
  input  logic [NT-1:0] clr_vec,
  input  logic [NT-1:0] en_set_vec,
  input  logic [NT-1:0] en_clr_vec,
  output logic [NT-1:0] pend_q,
  output logic [NT-1:0] en_q
);
  for (genvar i = 0; i < NT; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
      end else begin
        // a send in the same cycle outranks a clear
        pend_q[i] <= set_vec[i] | (pend_q[i] & ~clr_vec[i]);
        en_q[i]   <= en_set_vec[i] | (en_q[i] & ~en_clr_vec[i]);
      end
    end
  end
endmodule

// File: rtl/dbl_prio_pick.sv
module dbl_prio_pick
  import dbl_pkg::*;
#(
  parameter int NC = 4,
  parameter int NS = 8,
  localparam int NT = NC * NS
) (
  input  logic [NT-1:0]     live,
  output logic              hit,
  output logic [HALF_W-1:0] cid,
  output logic [HALF_W-1:0] sid
);
  always_comb begin
    hit = 1'b0;
    cid = '0;
    sid = '0;
    // scan from the top so the lowest live entry is the last written
    for (int c = NC - 1; c >= 0; c--) begin
      for (int s = NS - 1; s >= 0; s--) begin
        if (live[c*NS + s]) begin
          hit = 1'b1;
          cid = HALF_W'(c);
          sid = HALF_W'(s);
        end
      end
    end
  end
endmodule

// File: rtl/dbl_irq_ctrl.sv
module dbl_irq_ctrl
  import dbl_pkg::*;
#(
  parameter int NUM_CLIENTS = 4,
  parameter int NUM_SIGNALS = 8,
  parameter int ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rmt_send_vld,
  input  logic [31:0]       rmt_send_id,
  output logic              irq_out
);
  localparam int NT = NUM_CLIENTS * NUM_SIGNALS;

  cmd_e cmd;
  logic wr_stb;
  logic rd_recv;

  always_comb begin
    wr_stb = bus_sel && bus_we;
    cmd    = CMD_NONE;
    if (wr_stb) begin
      if      (bus_addr == ADDR_W'(OFF_SEND)) cmd = CMD_SEND;
      else if (bus_addr == ADDR_W'(OFF_EN))   cmd = CMD_EN;
      else if (bus_addr == ADDR_W'(OFF_DIS))  cmd = CMD_DIS;
      else if (bus_addr == ADDR_W'(OFF_CLR))  cmd = CMD_CLR;
    end
    rd_recv = bus_sel && !bus_we && (bus_addr == ADDR_W'(OFF_RECV));
  end

  logic [ID_W-1:0] dec_id   [N_SLOTS];
  logic            dec_act  [N_SLOTS];
  logic            dec_ok   [N_SLOTS];
  logic [NT-1:0]   dec_hot  [N_SLOTS];

  always_comb begin
    for (int k = 0; k < N_SLOTS; k++) begin
      dec_id[k]  = bus_wdata;
      dec_act[k] = 1'b0;
    end
    dec_id[SLOT_RSEND]  = rmt_send_id;
    dec_act[SLOT_BSEND] = (cmd == CMD_SEND);
    dec_act[SLOT_RSEND] = rmt_send_vld;
    dec_act[SLOT_EN]    = (cmd == CMD_EN);
    dec_act[SLOT_DIS]   = (cmd == CMD_DIS);
    dec_act[SLOT_CLR]   = (cmd == CMD_CLR);
  end

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_dec
    dbl_id_decode #(.NC(NUM_CLIENTS), .NS(NUM_SIGNALS)) u_dec (
      .act      (dec_act[k]),
      .id       (dec_id[k]),
      .in_range (dec_ok[k]),
      .hot      (dec_hot[k])
    );
  end

  // named event wires, also observed by the checker
  logic [NT-1:0] set_vec, clr_vec, en_set_vec, en_clr_vec;
  logic [NT-1:0] pend_q, en_q, live;

  assign set_vec    = dec_hot[SLOT_BSEND] | dec_hot[SLOT_RSEND];
  assign clr_vec    = dec_hot[SLOT_CLR];
  assign en_set_vec = dec_hot[SLOT_EN];
  assign en_clr_vec = dec_hot[SLOT_DIS];

  dbl_signal_bank #(.NT(NT)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .set_vec    (set_vec),
    .clr_vec    (clr_vec),
    .en_set_vec (en_set_vec),
    .en_clr_vec (en_clr_vec),
    .pend_q     (pend_q),
    .en_q       (en_q)
  );

  assign live = pend_q & en_q;

  logic              pick_hit;
  logic [HALF_W-1:0] pick_cid, pick_sid;
  logic [ID_W-1:0]   rx_id;

  dbl_prio_pick #(.NC(NUM_CLIENTS), .NS(NUM_SIGNALS)) u_pick (
    .live (live),
    .hit  (pick_hit),
    .cid  (pick_cid),
    .sid  (pick_sid)
  );

  assign rx_id     = pick_hit ? pack_id(pick_cid, pick_sid) : NONE_ID;
  assign irq_out   = pick_hit;
  assign bus_rdata = rd_recv ? rx_id : '0;
endmodule

// File: rtl/dbl_irq_ctrl_chk.sv
module dbl_irq_ctrl_chk #(
  parameter int NC = 4,
  parameter int NS = 8,
  localparam int NT = NC * NS
) (
  input logic          clk,
  input logic          rst,
  input logic [NT-1:0] pend_q,
  input logic [NT-1:0] en_q,
  input logic [NT-1:0] set_vec,
  input logic [NT-1:0] clr_vec,
  input logic [NT-1:0] en_set_vec,
  input logic [NT-1:0] en_clr_vec,
  input logic          irq_out,
  input logic [31:0]   rx_id
);
  a_r5_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|(pend_q & en_q)));

  a_r2_sentinel: assert property (@(posedge clk) disable iff (rst)
    !irq_out |-> (rx_id == 32'hFFFF_FFFF));

  a_r8_reported_in_range: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ((int'(rx_id[31:16]) < NC) && (int'(rx_id[15:0]) < NS)));

  a_r10_send_wins: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

  a_r4_clear_takes: assert property (@(posedge clk) disable iff (rst)
    (|(clr_vec & ~set_vec)) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));

  a_r3_enable_takes: assert property (@(posedge clk) disable iff (rst)
    (|en_set_vec) |=> ((en_q & $past(en_set_vec)) == $past(en_set_vec)));

  a_r3_disable_takes: assert property (@(posedge clk) disable iff (rst)
    (|(en_clr_vec & ~en_set_vec)) |=> ((en_q & $past(en_clr_vec & ~en_set_vec)) == '0));

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (pend_q == '0 && en_q == '0));
endmodule

bind dbl_irq_ctrl dbl_irq_ctrl_chk #(.NC(NUM_CLIENTS), .NS(NUM_SIGNALS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pend_q     (pend_q),
  .en_q       (en_q),
  .set_vec    (set_vec),
  .clr_vec    (clr_vec),
  .en_set_vec (en_set_vec),
  .en_clr_vec (en_clr_vec),
  .irq_out    (irq_out),
  .rx_id      (rx_id)
);

// File: tb/dbl_irq_ctrl_bench.sv
module dbl_irq_ctrl_bench;
  localparam int NCL = 4;
  localparam int NSG = 8;
  localparam logic [31:0] SENT = 32'hFFFF_FFFF;
  localparam logic [7:0] A_SEND = 8'h0C, A_RECV = 8'h10, A_EN = 8'h14,
                         A_DIS = 8'h18, A_CLR = 8'h1C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rmt_send_vld = 1'b0;
  logic [31:0] rmt_send_id = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbl_irq_ctrl #(.NUM_CLIENTS(NCL), .NUM_SIGNALS(NSG), .ADDR_W(8)) u_dbl_irq_ctrl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rmt_send_vld(rmt_send_vld),
    .rmt_send_id(rmt_send_id), .irq_out(irq_out)
  );

  function automatic logic [31:0] mk(int c, int s);
    return {16'(c), 16'(s)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    rd(A_RECV, v);
    chk("R11 recv after reset", v, SENT);
    chk("R11 irq after reset", 32'(irq_out), 0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    wr(A_EN, mk(1, 3));
    chk("R5 irq idle with only enable", 32'(irq_out), 0);
    wr(A_SEND, mk(1, 3));
    chk("R5 irq on enabled pending", 32'(irq_out), 1);
    rd(A_RECV, v);
    chk("R1 R2 recv id", v, mk(1, 3));
    wr(A_CLR, mk(1, 3));
    rd(A_RECV, v);
    chk("R4 recv after clear", v, SENT);
    chk("R4 irq after clear", 32'(irq_out), 0);
    wr(A_DIS, mk(1, 3));
  endtask

  task automatic t_latch_disabled();
    logic [31:0] v;
    wr(A_SEND, mk(2, 5));
    chk("R6 irq while disabled", 32'(irq_out), 0);
    rd(A_RECV, v);
    chk("R6 hidden while disabled", v, SENT);
    wr(A_EN, mk(2, 5));
    chk("R6 irq after enable", 32'(irq_out), 1);
    rd(A_RECV, v);
    chk("R6 visible after enable", v, mk(2, 5));
    wr(A_DIS, mk(2, 5));
    chk("R3 irq after disable", 32'(irq_out), 0);
    rd(A_RECV, v);
    chk("R3 recv after disable", v, SENT);
    wr(A_CLR, mk(2, 5));
    wr(A_EN, mk(2, 5));
    rd(A_RECV, v);
    chk("R4 clear while disabled", v, SENT);
    wr(A_DIS, mk(2, 5));
  endtask

  task automatic t_priority_drain();
    logic [31:0] v;
    logic [31:0] order [4];
    int n;
    order[0] = mk(1, 2); order[1] = mk(1, 7); order[2] = mk(2, 0); order[3] = mk(3, 0);
    for (int k = 0; k < 4; k++) wr(A_EN, order[k]);
    wr(A_SEND, mk(3, 0));
    wr(A_SEND, mk(2, 0));
    wr(A_SEND, mk(1, 7));
    wr(A_SEND, mk(1, 2));
    rd(A_RECV, v);
    chk("R7 lowest client then signal", v, mk(1, 2));
    n = 0;
    for (int k = 0; k < 6; k++) begin
      rd(A_RECV, v);
      if (v == SENT) break;
      if (n < 4) chk("R12 drain order", v, order[n]);
      n++;
      wr(A_CLR, v);
    end
    chk("R12 drained count", 32'(n), 4);
    chk("R12 irq after drain", 32'(irq_out), 0);
    for (int k = 0; k < 4; k++) wr(A_DIS, order[k]);
  endtask

  task automatic t_out_of_range();
    logic [31:0] v;
    wr(A_EN, mk(NCL, 0));
    wr(A_SEND, mk(NCL, 0));
    wr(A_EN, mk(0, NSG));
    wr(A_SEND, mk(0, NSG));
    chk("R8 irq after out-of-range", 32'(irq_out), 0);
    rd(A_RECV, v);
    chk("R8 recv after out-of-range", v, SENT);
    // a signal number of NSG must not alias to client 1 signal 0
    wr(A_EN, mk(1, 0));
    rd(A_RECV, v);
    chk("R8 no alias into neighbour", v, SENT);
    wr(A_SEND, mk(1, 0));
    wr(A_DIS, mk(1, NSG));
    wr(A_CLR, mk(1, NSG));
    rd(A_RECV, v);
    chk("R8 out-of-range disable/clear ignored", v, mk(1, 0));
    wr(A_CLR, mk(1, 0));
    wr(A_DIS, mk(1, 0));
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(A_EN, mk(0, 1));
    wr(A_SEND, mk(0, 1));
    wr(8'h24, mk(0, 2));
    rd(A_SEND, v);
    chk("R9 read send offset", v, 0);
    rd(A_EN, v);
    chk("R9 read enable offset", v, 0);
    rd(8'h24, v);
    chk("R9 read unmapped offset", v, 0);
    rd(A_RECV, v);
    chk("R2 recv unaffected by stray write", v, mk(0, 1));
    wr(A_CLR, mk(0, 1));
    wr(A_DIS, mk(0, 1));
  endtask

  task automatic t_collision();
    logic [31:0] v;
    wr(A_EN, mk(2, 2));
    @(negedge clk);
    rmt_send_vld = 1'b1; rmt_send_id = mk(2, 2);
    @(negedge clk);
    rmt_send_vld = 1'b0;
    rd(A_RECV, v);
    chk("R1 remote send", v, mk(2, 2));
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_CLR; bus_wdata = mk(2, 2);
    rmt_send_vld = 1'b1; rmt_send_id = mk(2, 2);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; rmt_send_vld = 1'b0;
    rd(A_RECV, v);
    chk("R10 send beats clear", v, mk(2, 2));
    wr(A_CLR, mk(2, 2));
    rd(A_RECV, v);
    chk("R10 later clear alone", v, SENT);
    wr(A_DIS, mk(2, 2));
  endtask

  task automatic t_mid_reset();
    logic [31:0] v;
    wr(A_EN, mk(3, 3));
    wr(A_SEND, mk(3, 3));
    chk("R5 irq before reset", 32'(irq_out), 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R11 irq after reset", 32'(irq_out), 0);
    wr(A_SEND, mk(3, 3));
    chk("R11 enable cleared by reset", 32'(irq_out), 0);
    wr(A_EN, mk(3, 3));
    rd(A_RECV, v);
    chk("R11 pending works after reset", v, mk(3, 3));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset_state();
    t_basic();
    t_latch_disabled();
    t_priority_drain();
    t_out_of_range();
    t_unmapped();
    t_collision();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule